// File: doc/BRIEF.md
# Transactional Line Buffer with Commit-Conflict Detection

This block is a small, fully associative buffer that sits next to a core's ordinary L1 data array. It serves only transactional loads and stores. Each entry holds one cache line with two data copies: the committed value and the speculative value that the running transaction has built up. Each entry also has one bit that marks the line as read by the transaction and one bit that marks it as written. A line that is not yet held is fetched over a shared bus. Speculative data stays inside the buffer until commit. On commit, the buffer sends the address of every written line onto a broadcast channel, one address per handshake. After that, every speculative copy becomes the committed copy in the same cycle.

The buffer also watches the commit broadcasts of other cores. A remote commit that names a line in the local read set or write set aborts the local transaction, so the committer always wins. An abort throws away every speculative copy. The abort status then stays high until the core begins a new transaction. A remote commit to a held line that the transaction has not touched only invalidates that line.

The core request, the bus line read and the commit broadcast are valid/ready channels. Each sender keeps valid high and its payload steady until ready is seen at a clock edge. The response channel has no back-pressure, so the core must take `rsp_valid` in the cycle it appears. Begin, commit, commit-done, abort status and snoop are plain single-cycle or level signals.

Top module: `txn_line_buffer`

## Requirements
- R1: After reset no transaction is open: `tx_aborted`, `req_ready`, `bus_rd_valid`, `bc_valid`, `commit_done` and `rsp_valid` are low, and no line is held.
- R2: A transactional load of a line that is not held raises `bus_rd_valid` with that line address, and the load then gets a one-cycle response. The response data equals the line data returned on `fill_data`.
- R3: An access to a line that is already held makes no bus read. Its response appears in the cycle after the request handshake, and at most one entry matches any address.
- R4: A store writes byte b of `req_wdata` into the line only where `req_be[b]` is 1, with byte b at bits 8b+7..8b. A store to a line that is not held first fetches the line, then merges over the fetched data. The store response, and later loads in the same transaction, return the merged line.
- R5: An abort discards every speculative copy and clears both set masks. A later transaction that reads a line written in the aborted transaction sees the value from before that transaction, with no bus read.
- R6: After `tx_commit`, the address of each written line is sent once on `bc_addr`, one per accepted handshake. Lower-numbered entries go first; after reset, entries fill in the order the lines were first touched.
- R7: `commit_done` pulses for one cycle, in the cycle after the last broadcast handshake (or one cycle after `tx_commit` if nothing was written). In that cycle both set masks clear, and the speculative values become the committed values seen by later transactions.
- R8: A snoop whose address matches a line in the read set aborts the transaction, and `tx_aborted` is high from the next cycle.
- R9: A snoop whose address matches a line that is in the write set only also aborts the transaction.
- R10: A snoop to a held line that is in neither set does not abort. It invalidates the line, so the next access to that line fetches it again.
- R11: While every entry belongs to the read or write set, an access to a further line causes a capacity abort. That access gets no response and makes no bus read.
- R12: `tx_aborted` stays high until `tx_begin`. Accesses made while aborted are accepted and dropped, with no response and no bus read. A commit while aborted sends nothing and gives no `commit_done`.
- R13: `req_ready` is low while a line fetch or a commit is in progress. `bus_rd_addr` and `bc_addr` stay steady while their valid is high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_begin | input | 1 | Opens a transaction (when idle or aborted) |
| tx_commit | input | 1 | Requests commit of the open transaction |
| req_valid | input | 1 | Core access valid |
| req_ready | output | 1 | Buffer can take a core access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Line address of the access |
| req_wdata | input | 8*LINE_BYTES | Store data |
| req_be | input | LINE_BYTES | Store byte enables |
| rsp_valid | output | 1 | One-cycle access response |
| rsp_data | output | 8*LINE_BYTES | Line value seen by the access |
| tx_aborted | output | 1 | Transaction aborted, held until begin |
| commit_done | output | 1 | One-cycle commit completion pulse |
| bus_rd_valid | output | 1 | Line read request valid |
| bus_rd_ready | input | 1 | Bus accepts the line read |
| bus_rd_addr | output | ADDR_W | Line read address |
| fill_valid | input | 1 | Read data returned (after the read handshake) |
| fill_data | input | 8*LINE_BYTES | Returned line data |
| bc_valid | output | 1 | Commit broadcast valid |
| bc_ready | input | 1 | Bus accepts the broadcast address |
| bc_addr | output | ADDR_W | Address of a written line being published |
| snoop_valid | input | 1 | Remote commit address valid |
| snoop_addr | input | ADDR_W | Line address published by another core |

## Verification
The assertions check, every cycle, the properties that can be seen locally. Addresses must match at most one entry, and a hit must be answered in the next cycle. Requests on the bus-read and broadcast channels must hold steady under back-pressure, and the broadcast must drain one address per handshake. Both set masks must be empty at each abort and after `commit_done`, and a snooped conflict must raise the abort status. Only the bench scenarios can show the end-to-end data behaviour. These are: byte merging over fetched lines, discarding of speculative data after an abort, speculative values becoming committed values for the next transaction, the order of broadcast addresses, and refetching after a harmless snoop. The bench also covers the capacity abort on the first access past the last free entry and the exact cycle in which `commit_done` arrives.

// File: rtl/txn_buf_pkg.sv
package txn_buf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_FETCH,
    ST_COMMIT,
    ST_ABORTED
  } tx_state_e;
endpackage

// File: rtl/txn_first_set.sv
module txn_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |mask;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/txn_tag_match.sv
module txn_tag_match #(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input  logic [N-1:0]  valid,
  input  logic [AW-1:0] tags [N],
  input  logic [AW-1:0] key,
  output logic [N-1:0]  hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/txn_commit_seq.sv
module txn_commit_seq #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  load_mask,
  input  logic          run,
  input  logic [AW-1:0] tags [N],
  input  logic          bc_ready,
  output logic          bc_valid,
  output logic [AW-1:0] bc_addr,
  output logic          busy
);
  logic [N-1:0]  pend;
  logic          found;
  logic [IW-1:0] idx;

  txn_first_set #(.N(N), .IW(IW)) u_pick (
    .mask (pend),
    .found(found),
    .idx  (idx)
  );

  assign busy     = found;
  assign bc_valid = run && found;
  assign bc_addr  = tags[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (load) begin
      pend <= load_mask;
    end else if (bc_valid && bc_ready) begin
      pend[idx] <= 1'b0;
    end
  end

  assert_bc_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !bc_ready) |=> (bc_valid && $stable(bc_addr)));

  assert_bc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_ready) |=> ($countones(pend) + 1 == $countones($past(pend))));
endmodule

// File: rtl/txn_line_buffer.sv
module txn_line_buffer
  import txn_buf_pkg::*;
#(
  parameter int N_LINES    = 8,
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_begin,
  input  logic                    tx_commit,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_store,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [8*LINE_BYTES-1:0] req_wdata,
  input  logic [LINE_BYTES-1:0]   req_be,
  output logic                    rsp_valid,
  output logic [8*LINE_BYTES-1:0] rsp_data,
  output logic                    tx_aborted,
  output logic                    commit_done,
  output logic                    bus_rd_valid,
  input  logic                    bus_rd_ready,
  output logic [ADDR_W-1:0]       bus_rd_addr,
  input  logic                    fill_valid,
  input  logic [8*LINE_BYTES-1:0] fill_data,
  output logic                    bc_valid,
  input  logic                    bc_ready,
  output logic [ADDR_W-1:0]       bc_addr,
  input  logic                    snoop_valid,
  input  logic [ADDR_W-1:0]       snoop_addr
);
  localparam int LW = 8 * LINE_BYTES;
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  tx_state_e         state;
  logic [N_LINES-1:0] ent_v, rset, wset;
  logic [ADDR_W-1:0] ent_tag [N_LINES];
  logic [LW-1:0]     old_d   [N_LINES];
  logic [LW-1:0]     new_d   [N_LINES];

  logic              p_store;
  logic [ADDR_W-1:0] p_addr;
  logic [LW-1:0]     p_wdata;
  logic [LINE_BYTES-1:0] p_be;
  logic [IW-1:0]     p_idx;
  logic              rd_sent, abort_pend;

  logic [N_LINES-1:0] req_hit, snp_hit;
  logic              req_found, inv_found, avl_found, alloc_ok;
  logic [IW-1:0]     req_idx, inv_idx, avl_idx, alloc_idx;
  logic              snp_conf, cap_abort, abort_now, req_fire;
  logic              seq_load, seq_busy;
  logic [LW-1:0]     st_merge, fill_merge;

  function automatic logic [LW-1:0] merge_bytes(input logic [LW-1:0] base,
                                                input logic [LW-1:0] wd,
                                                input logic [LINE_BYTES-1:0] be);
    logic [LW-1:0] r;
    r = base;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (be[b]) r[8*b +: 8] = wd[8*b +: 8];
    end
    return r;
  endfunction

  txn_tag_match #(.N(N_LINES), .AW(ADDR_W)) u_req_match (
    .valid(ent_v), .tags(ent_tag), .key(req_addr), .hit(req_hit)
  );
  txn_tag_match #(.N(N_LINES), .AW(ADDR_W)) u_snp_match (
    .valid(ent_v), .tags(ent_tag), .key(snoop_addr), .hit(snp_hit)
  );
  txn_first_set #(.N(N_LINES), .IW(IW)) u_req_pick (
    .mask(req_hit), .found(req_found), .idx(req_idx)
  );
  txn_first_set #(.N(N_LINES), .IW(IW)) u_inv_pick (
    .mask(~ent_v), .found(inv_found), .idx(inv_idx)
  );
  txn_first_set #(.N(N_LINES), .IW(IW)) u_avl_pick (
    .mask(~(rset | wset)), .found(avl_found), .idx(avl_idx)
  );

  assign alloc_ok  = inv_found || avl_found;
  assign alloc_idx = inv_found ? inv_idx : avl_idx;

  assign req_ready   = (state == ST_ACTIVE && !tx_commit) || (state == ST_ABORTED);
  assign req_fire    = req_valid && req_ready;
  assign snp_conf    = snoop_valid && |(snp_hit & (rset | wset));
  assign cap_abort   = (state == ST_ACTIVE) && !snp_conf && req_fire && !req_found && !alloc_ok;
  assign abort_now   = ((state == ST_ACTIVE || state == ST_FETCH) && snp_conf) || cap_abort;
  assign tx_aborted  = (state == ST_ABORTED) || (state == ST_FETCH && abort_pend);
  assign bus_rd_valid = (state == ST_FETCH) && !rd_sent;
  assign bus_rd_addr  = p_addr;
  assign commit_done  = (state == ST_COMMIT) && !seq_busy;
  assign seq_load     = (state == ST_ACTIVE) && tx_commit && !snp_conf;

  assign st_merge   = merge_bytes(new_d[req_idx], req_wdata, req_be);
  assign fill_merge = p_store ? merge_bytes(fill_data, p_wdata, p_be) : fill_data;

  txn_commit_seq #(.N(N_LINES), .AW(ADDR_W), .IW(IW)) u_commit (
    .clk(clk), .rst_n(rst_n), .load(seq_load), .load_mask(wset),
    .run(state == ST_COMMIT), .tags(ent_tag), .bc_ready(bc_ready),
    .bc_valid(bc_valid), .bc_addr(bc_addr), .busy(seq_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ent_v      <= '0;
      rset       <= '0;
      wset       <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      p_store    <= 1'b0;
      p_addr     <= '0;
      p_wdata    <= '0;
      p_be       <= '0;
      p_idx      <= '0;
      rd_sent    <= 1'b0;
      abort_pend <= 1'b0;
      for (int i = 0; i < N_LINES; i++) begin
        ent_tag[i] <= '0;
        old_d[i]   <= '0;
        new_d[i]   <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      // remote commits make held copies stale; the commit phase owns the bus
      if (state != ST_COMMIT) begin
        for (int i = 0; i < N_LINES; i++) begin
          if (snoop_valid && snp_hit[i]) ent_v[i] <= 1'b0;
        end
      end
      unique case (state)
        ST_IDLE: if (tx_begin) state <= ST_ACTIVE;
        ST_ACTIVE: begin
          if (abort_now) begin
            state <= ST_ABORTED;
          end else if (tx_commit) begin
            state <= ST_COMMIT;
          end else if (req_fire) begin
            if (req_found) begin
              if (req_store) begin
                new_d[req_idx] <= st_merge;
                wset[req_idx]  <= 1'b1;
                rsp_data       <= st_merge;
              end else begin
                rset[req_idx]  <= 1'b1;
                rsp_data       <= new_d[req_idx];
              end
              rsp_valid <= 1'b1;
            end else begin
              p_store    <= req_store;
              p_addr     <= req_addr;
              p_wdata    <= req_wdata;
              p_be       <= req_be;
              p_idx      <= alloc_idx;
              ent_v[alloc_idx] <= 1'b0;
              rd_sent    <= 1'b0;
              abort_pend <= 1'b0;
              state      <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (bus_rd_valid && bus_rd_ready) rd_sent <= 1'b1;
          if (snp_conf) abort_pend <= 1'b1;
          if (fill_valid && rd_sent) begin
            if (abort_pend || snp_conf) begin
              state <= ST_ABORTED;
            end else begin
              ent_v[p_idx]   <= 1'b1;
              ent_tag[p_idx] <= p_addr;
              old_d[p_idx]   <= fill_data;
              new_d[p_idx]   <= fill_merge;
              if (p_store) wset[p_idx] <= 1'b1;
              else         rset[p_idx] <= 1'b1;
              rsp_valid <= 1'b1;
              rsp_data  <= fill_merge;
              state     <= ST_ACTIVE;
            end
          end
        end
        ST_COMMIT: begin
          if (!seq_busy) begin
            for (int i = 0; i < N_LINES; i++) old_d[i] <= new_d[i];
            rset  <= '0;
            wset  <= '0;
            state <= ST_IDLE;
          end
        end
        ST_ABORTED: begin
          if (tx_begin) begin
            state      <= ST_ACTIVE;
            abort_pend <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (abort_now) begin
        for (int i = 0; i < N_LINES; i++) new_d[i] <= old_d[i];
        rset <= '0;
        wset <= '0;
      end
    end
  end

  assert_unique_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(req_hit));

  assert_hit_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && req_fire && req_found && !snp_conf) |=> rsp_valid);

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_valid && !bus_rd_ready) |=> (bus_rd_valid && $stable(bus_rd_addr)));

  assert_sets_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> ((rset == '0) && (wset == '0) && !tx_aborted));

  assert_abort_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_aborted) |-> ((rset | wset) == '0));

  assert_aborted_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ABORTED && req_valid && !tx_begin) |=> (!rsp_valid && !bus_rd_valid));

  assert_conflict_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && snp_conf) |=> tx_aborted);
endmodule

// File: tb/txn_line_buffer_bench.sv
module txn_line_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_begin = 1'b0, tx_commit = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, tx_aborted, commit_done;
  logic [31:0] rsp_data;
  logic        bus_rd_valid, bus_rd_ready;
  logic [15:0] bus_rd_addr;
  logic        fill_valid;
  logic [31:0] fill_data;
  logic        bc_valid, bc_ready;
  logic [15:0] bc_addr;
  logic        snoop_valid = 1'b0;
  logic [15:0] snoop_addr = '0;

  int n_checks = 0, n_fail = 0;
  int rd_count = 0, rd_stall = 0, bc_block = 0, bc_n = 0;
  logic [15:0] rd_addr_seen = '0;
  logic [15:0] bc_log [16];

  always #10 clk = ~clk;

  txn_line_buffer u_txn_line_buffer (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tx_aborted(tx_aborted),
    .commit_done(commit_done), .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready),
    .bus_rd_addr(bus_rd_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_addr(bc_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
  );

  function automatic logic [31:0] mem_of(input logic [15:0] a);
    return {a ^ 16'hA5A5, a};
  endfunction

  // fields: store, addr, wdata, be, expected response, expects a bus read
  localparam logic [85:0] VECS [8] = '{
    {1'b0, 16'h0010, 32'h0000_0000, 4'h0, 32'hA5B5_0010, 1'b1},
    {1'b0, 16'h0010, 32'h0000_0000, 4'h0, 32'hA5B5_0010, 1'b0},
    {1'b1, 16'h0010, 32'h1122_3344, 4'h3, 32'hA5B5_3344, 1'b0},
    {1'b0, 16'h0010, 32'h0000_0000, 4'h0, 32'hA5B5_3344, 1'b0},
    {1'b1, 16'h0020, 32'hDEAD_BEEF, 4'hC, 32'hDEAD_0020, 1'b1},
    {1'b0, 16'h0020, 32'h0000_0000, 4'h0, 32'hDEAD_0020, 1'b0},
    {1'b0, 16'h0030, 32'h0000_0000, 4'h0, 32'hA595_0030, 1'b1},
    {1'b1, 16'h0030, 32'hCAFE_F00D, 4'hF, 32'hCAFE_F00D, 1'b0}
  };

  // bus read responder
  initial begin
    bus_rd_ready = 1'b0; fill_valid = 1'b0; fill_data = '0;
    forever begin
      @(negedge clk);
      fill_valid = 1'b0;
      if (bus_rd_valid) begin
        for (int s = 0; s < rd_stall; s++) @(negedge clk);
        bus_rd_ready = 1'b1;
        rd_addr_seen = bus_rd_addr;
        rd_count++;
        @(negedge clk);
        bus_rd_ready = 1'b0;
        fill_valid   = 1'b1;
        fill_data    = mem_of(rd_addr_seen);
      end
    end
  end

  // broadcast sink
  initial begin
    bc_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (bc_valid && bc_block > 0) begin
        bc_ready = 1'b0;
        bc_block--;
      end else begin
        bc_ready = 1'b1;
      end
      if (bc_valid && bc_ready) begin
        bc_log[bc_n] = bc_addr;
        bc_n++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_access(input logic st, input logic [15:0] a, input logic [31:0] d,
                           input logic [3:0] b, output logic got, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d; req_be = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0; rd = '0;
    for (int k = 0; k < 20 && !got; k++) begin
      if (rsp_valid) begin got = 1'b1; rd = rsp_data; end
      else @(negedge clk);
    end
  endtask

  task automatic do_begin();
    @(negedge clk); tx_begin = 1'b1;
    @(negedge clk); tx_begin = 1'b0;
  endtask

  task automatic do_snoop(input logic [15:0] a);
    @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk); snoop_valid = 1'b0;
  endtask

  task automatic do_commit(output int cyc, output logic done);
    @(negedge clk); tx_commit = 1'b1;
    @(negedge clk); tx_commit = 1'b0;
    cyc = 1; done = 1'b0;
    for (int k = 0; k < 30 && !done; k++) begin
      if (commit_done) done = 1'b1;
      else begin @(negedge clk); cyc++; end
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic        got;
    logic [31:0] rd;
    int          rc0, bn0, cyc;
    logic        done;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 tx_aborted", 32'(tx_aborted), 0);
    chk("R1 req_ready", 32'(req_ready), 0);
    chk("R1 bus_rd_valid", 32'(bus_rd_valid), 0);
    chk("R1 bc_valid", 32'(bc_valid), 0);
    chk("R1 commit_done", 32'(commit_done), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);

    do_begin();
    for (int i = 0; i < 8; i++) begin
      logic [85:0] v;
      string tag;
      v = VECS[i];
      tag = v[85] ? "R4" : (v[0] ? "R2" : "R3");
      rc0 = rd_count;
      do_access(v[85], v[84:69], v[68:37], v[36:33], got, rd);
      chk({tag, " response"}, 32'(got), 1);
      chk({tag, " data"}, rd, v[32:1]);
      chk({tag, " bus reads"}, 32'(rd_count - rc0), 32'(v[0]));
      if (v[0]) chk("R2 read address", 32'(rd_addr_seen), 32'(v[84:69]));
    end

    // R6 / R7 commit of three written lines
    bn0 = bc_n;
    do_commit(cyc, done);
    chk("R7 commit_done seen", 32'(done), 1);
    chk("R7 commit_done cycle", 32'(cyc), 4);
    chk("R6 broadcast count", 32'(bc_n - bn0), 3);
    chk("R6 first addr", 32'(bc_log[bn0]), 32'h0010);
    chk("R6 second addr", 32'(bc_log[bn0 + 1]), 32'h0020);
    chk("R6 third addr", 32'(bc_log[bn0 + 2]), 32'h0030);

    // R7 committed data visible; then R8 abort and R5 discard
    do_begin();
    rc0 = rd_count;
    do_access(1'b0, 16'h0010, 0, 0, got, rd);
    chk("R7 committed value", rd, 32'hA5B5_3344);
    chk("R7 no bus read", 32'(rd_count - rc0), 0);
    do_access(1'b1, 16'h0020, 32'h1234_5678, 4'hF, got, rd);
    chk("R4 full store", rd, 32'h1234_5678);
    do_access(1'b0, 16'h0030, 0, 0, got, rd);
    chk("R3 hit load", rd, 32'hCAFE_F00D);
    do_snoop(16'h0030);
    chk("R8 read-set conflict aborts", 32'(tx_aborted), 1);

    // R12 behaviour while aborted
    rc0 = rd_count;
    do_access(1'b0, 16'h0020, 0, 0, got, rd);
    chk("R12 dropped access no response", 32'(got), 0);
    chk("R12 dropped access no bus read", 32'(rd_count - rc0), 0);
    bn0 = bc_n;
    do_commit(cyc, done);
    chk("R12 commit ignored", 32'(done), 0);
    chk("R12 no broadcast", 32'(bc_n - bn0), 0);
    chk("R12 abort held", 32'(tx_aborted), 1);
    do_begin();
    chk("R12 begin clears abort", 32'(tx_aborted), 0);

    rc0 = rd_count;
    do_access(1'b0, 16'h0020, 0, 0, got, rd);
    chk("R5 speculative store discarded", rd, 32'hDEAD_0020);
    chk("R5 no bus read", 32'(rd_count - rc0), 0);

    // R10 harmless snoop invalidates
    do_snoop(16'h0010);
    chk("R10 no abort", 32'(tx_aborted), 0);
    rc0 = rd_count;
    do_access(1'b0, 16'h0010, 0, 0, got, rd);
    chk("R10 refetch", 32'(rd_count - rc0), 1);
    chk("R10 refetched data", rd, mem_of(16'h0010));

    // R4 store miss, then R9 write-set conflict
    do_access(1'b1, 16'h0040, 32'h0000_00AA, 4'h1, got, rd);
    chk("R4 store miss merge", rd, 32'hA5E5_00AA);
    do_snoop(16'h0040);
    chk("R9 write-set conflict aborts", 32'(tx_aborted), 1);

    // R11 capacity abort
    do_begin();
    rc0 = rd_count;
    for (int i = 0; i < 8; i++) begin
      do_access(1'b0, 16'h0100 + 16'(i), 0, 0, got, rd);
      chk("R11 fill within capacity", rd, mem_of(16'h0100 + 16'(i)));
    end
    do_access(1'b0, 16'h0108, 0, 0, got, rd);
    chk("R11 overflow no response", 32'(got), 0);
    chk("R11 overflow aborts", 32'(tx_aborted), 1);
    chk("R11 overflow no bus read", 32'(rd_count - rc0), 8);

    // R13 back-pressure on both bus channels
    do_begin();
    @(posedge clk); rd_stall = 3;
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_addr = 16'h0200;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 ready low during fetch", 32'(req_ready), 0);
    chk("R13 read request held", 32'(bus_rd_valid), 1);
    got = 1'b0;
    for (int k = 0; k < 20 && !got; k++) begin
      if (rsp_valid) begin got = 1'b1; rd = rsp_data; end
      else @(negedge clk);
    end
    chk("R13 stalled fill data", rd, mem_of(16'h0200));
    @(posedge clk); rd_stall = 0;
    do_access(1'b1, 16'h0200, 32'h0BAD_CAFE, 4'hF, got, rd);
    @(posedge clk); bc_block = 3;
    bn0 = bc_n;
    do_commit(cyc, done);
    chk("R13 commit under back-pressure", 32'(cyc), 5);
    chk("R13 single broadcast", 32'(bc_n - bn0), 1);
    chk("R13 broadcast addr", 32'(bc_log[bn0]), 32'h0200);

    do_begin();
    rc0 = rd_count;
    do_access(1'b0, 16'h0200, 0, 0, got, rd);
    chk("R7 published store", rd, 32'h0BAD_CAFE);
    chk("R7 published no bus read", 32'(rd_count - rc0), 0);

    finish_run();
  end
endmodule